// File: doc/BRIEF.md
# NOR Flash Read-Data Selector

This block forms the data returned on every read of a parallel NOR flash device model. The command sequencer next to it tells it which command mode the device is in. From that mode the block picks the source of the read word. The source is one of four: the storage array, the identifier words, the erase/program status byte, or the common flash interface (CFI) query table. The query table is not stored. It is computed from the sector size, the sector count and the identifier parameters, so a change of geometry needs no new table contents.

The storage array is a small internal byte memory. At reset every byte is in the erased state. The sequencer programs bytes through a one-byte port, and a program can only clear bits. A read is one strobe with a byte address and an access size. The result appears, with a valid flag, on the following clock cycle. Locations that decode per device word use an index taken from the low address byte. That index is scaled by the configured device width.

Top module: `nor_read_mux`

## Requirements
- R1: A read strobe in cycle N gives `rdValid` high and the new `rdData` in cycle N+1. With no strobe, `rdValid` is low in the next cycle and `rdData` keeps its value. After reset both outputs are zero.
- R2: The decode index is the low 8 address bits shifted right by 0, 1 or 2 for a device width of 1, 2 or 4 bytes. For example, with a 2-byte device, addresses 0 and 1 both decode to index 0.
- R3: Array data is returned in mode 0 (read) and in mode 1 (erase setup). `rdSize` 0, 1 and 2 select 1, 2 and 4 bytes starting at the address, and the address wraps at the end of the array. With little-endian order, which is the default, the byte at the lowest address sits in bits 7:0.
- R4: For a 1-byte array access, `rdData[31:8]` is zero. For a 2-byte access of any source, `rdData[31:16]` is zero.
- R5: In mode 2 (autoselect), index 0 returns the manufacturer word, index 1 returns the device word, and index 2 returns 0, which means no sector is protected.
- R6: In mode 2, index 0x0E returns extended word A and index 0x0F returns extended word B. If that word is 0xFFFF, array data is returned instead. Every other index in mode 2 also returns array data.
- R7: In mode 3 (query), a read returns the table byte at the index, zero-extended. The table holds "QRY" at 0x10-0x12, 0x02 at 0x13, 0x31 at 0x15, and "PRI10" at 0x31-0x35. It also holds the timeouts 0x09/0x0C/0x0A/0x0D at 0x21/0x22/0x25/0x26, log2 of the device size at 0x27, 0 at 0x2A and 1 at 0x2C. Bytes 0x2D-0x2E hold the sector count minus one and bytes 0x2F-0x30 hold the sector size divided by 256, both low byte first. Unlisted bytes are 0, except 0x27 at 0x1B, 0x36 at 0x1C, 0x07 at 0x1F, 0x01 at 0x23 and 0x02 at 0x28.
- R8: In mode 3, any index of 0x52 or above returns 0.
- R9: In modes 4 (program), 5 (chip erase) and 6 (sector erase), a read returns `statusIn` with bit 6 inverted on every second such read since reset. The first such read returns `statusIn` unchanged. Reads in other modes do not advance this alternation.
- R10: After reset every array byte reads 0xFF. A program cycle (`progEn`) replaces the addressed byte with the AND of its old value and `progData`.
- R11: The unused mode code 7 returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStb | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdSize | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| modeIn | input | 3 | Command mode from the sequencer |
| statusIn | input | 8 | Status byte from the sequencer |
| progEn | input | 1 | Program one array byte |
| progAddr | input | ADDR_W | Byte address to program |
| progData | input | 8 | Data ANDed into the array byte |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | Read data valid |

## Verification
The hardest cases to reach are those where the result depends on earlier history rather than on the current inputs. Two such cases exist: the bit-6 alternation of the status byte, and the array contents behind an unprogrammed extended word. For the first, the stimulus places status reads in different modes with array reads between them. This shows that only status reads advance the alternation. For the second, the stimulus fills the whole array with a known pattern and then programs one byte a second time, which proves the AND rule. Autoselect reads at the extended-word indices must then return that pattern wherever the word is 0xFFFF. Query reads use odd and even addresses to exercise the width-scaled index.

// File: rtl/nor_read_mux_pkg.sv
package nor_read_mux_pkg;

  typedef enum logic [2:0] {
    MODE_READ        = 3'd0,
    MODE_ERASE_SETUP = 3'd1,
    MODE_AUTOSEL     = 3'd2,
    MODE_QUERY       = 3'd3,
    MODE_PROGRAM     = 3'd4,
    MODE_CHIP_ERASE  = 3'd5,
    MODE_SECT_ERASE  = 3'd6,
    MODE_SPARE       = 3'd7
  } flashMode_e;

  typedef enum logic [2:0] {
    SRC_ARRAY  = 3'd0,
    SRC_IDENT  = 3'd1,
    SRC_ZERO   = 3'd2,
    SRC_STATUS = 3'd3,
    SRC_QUERY  = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic       fire;
    rdSrc_e     src;
    logic [1:0] idSel;
    logic [7:0] idx;
  } rdCtl_t;

  localparam int unsigned QUERY_LEN = 32'h52;
  localparam logic [15:0] ID_BLANK  = 16'hFFFF;

  // Query table byte, computed from device geometry.
  function automatic logic [7:0] queryByte(input logic [7:0] idx,
                                           input int unsigned sectBytes,
                                           input int unsigned sectCount,
                                           input int unsigned sizeLog2);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      8'h10: b = 8'h51;
      8'h11: b = 8'h52;
      8'h12: b = 8'h59;
      8'h13: b = 8'h02;
      8'h15: b = 8'h31;
      8'h1B: b = 8'h27;
      8'h1C: b = 8'h36;
      8'h1F: b = 8'h07;
      8'h21: b = 8'h09;
      8'h22: b = 8'h0C;
      8'h23: b = 8'h01;
      8'h25: b = 8'h0A;
      8'h26: b = 8'h0D;
      8'h27: b = 8'(sizeLog2);
      8'h28: b = 8'h02;
      8'h2C: b = 8'h01;
      8'h2D: b = 8'(sectCount - 1);
      8'h2E: b = 8'((sectCount - 1) >> 8);
      8'h2F: b = 8'(sectBytes >> 8);
      8'h30: b = 8'(sectBytes >> 16);
      8'h31: b = 8'h50;
      8'h32: b = 8'h52;
      8'h33: b = 8'h49;
      8'h34: b = 8'h31;
      8'h35: b = 8'h30;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nor_read_mux_ctrl.sv
module nor_read_mux_ctrl
  import nor_read_mux_pkg::*;
#(
  parameter int          DEV_BYTES = 2,
  parameter logic [15:0] EXT_ID_A  = 16'h2210,
  parameter logic [15:0] EXT_ID_B  = 16'hFFFF
) (
  input  logic       rdStb,
  input  logic [7:0] addrLow,
  input  logic [2:0] modeIn,
  output rdCtl_t     ctl
);

  localparam int IDX_SHIFT = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);
  localparam bit EXT_A_BLANK = (EXT_ID_A == ID_BLANK);
  localparam bit EXT_B_BLANK = (EXT_ID_B == ID_BLANK);

  logic [7:0] idx;
  flashMode_e mode;

  assign idx  = addrLow >> IDX_SHIFT;
  assign mode = flashMode_e'(modeIn);

  always_comb begin
    ctl       = '0;
    ctl.fire  = rdStb;
    ctl.idx   = idx;
    ctl.src   = SRC_ARRAY;
    ctl.idSel = 2'd0;
    case (mode)
      MODE_AUTOSEL: begin
        case (idx)
          8'h00: begin ctl.src = SRC_IDENT; ctl.idSel = 2'd0; end
          8'h01: begin ctl.src = SRC_IDENT; ctl.idSel = 2'd1; end
          8'h02: ctl.src = SRC_ZERO;
          8'h0E: if (!EXT_A_BLANK) begin ctl.src = SRC_IDENT; ctl.idSel = 2'd2; end
          8'h0F: if (!EXT_B_BLANK) begin ctl.src = SRC_IDENT; ctl.idSel = 2'd3; end
          default: ctl.src = SRC_ARRAY;
        endcase
      end
      MODE_QUERY:
        ctl.src = (32'(idx) >= QUERY_LEN) ? SRC_ZERO : SRC_QUERY;
      MODE_PROGRAM, MODE_CHIP_ERASE, MODE_SECT_ERASE:
        ctl.src = SRC_STATUS;
      default:
        ctl.src = SRC_ARRAY;
    endcase
  end

endmodule

// File: rtl/nor_read_mux_dp.sv
module nor_read_mux_dp
  import nor_read_mux_pkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter int          SECT_BYTES = 256,
  parameter int          SECT_COUNT = 2,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  parameter logic [15:0] DEV_ID     = 16'h227E,
  parameter logic [15:0] EXT_ID_A   = 16'h2210,
  parameter logic [15:0] EXT_ID_B   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            ctl,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic [7:0]        statusIn,
  input  logic              progEn,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  localparam int ARR_BYTES  = SECT_BYTES * SECT_COUNT;
  localparam int SIZE_LOG2  = $clog2(ARR_BYTES);

  logic [7:0]  mem [ARR_BYTES];
  logic [31:0] arrWord;
  logic [31:0] idWord;
  logic [31:0] nextData;
  logic        toggleQ;
  int          nBytes;

  // Storage array: erased at reset, programming only clears bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARR_BYTES; i++) mem[i] <= 8'hFF;
    end else if (progEn) begin
      mem[progAddr] <= mem[progAddr] & progData;
    end
  end

  // Array word assembly with address wrap and selectable byte order.
  always_comb begin
    case (rdSize)
      2'd0:    nBytes = 1;
      2'd1:    nBytes = 2;
      default: nBytes = 4;
    endcase
    arrWord = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < nBytes) begin
        if (BIG_ENDIAN)
          arrWord = arrWord | (32'(mem[rdAddr + ADDR_W'(k)]) << (8 * (nBytes - 1 - k)));
        else
          arrWord = arrWord | (32'(mem[rdAddr + ADDR_W'(k)]) << (8 * k));
      end
    end
  end

  always_comb begin
    case (ctl.idSel)
      2'd0:    idWord = 32'(MFR_ID);
      2'd1:    idWord = 32'(DEV_ID);
      2'd2:    idWord = 32'(EXT_ID_A);
      default: idWord = 32'(EXT_ID_B);
    endcase
  end

  always_comb begin
    case (ctl.src)
      SRC_IDENT:  nextData = idWord;
      SRC_ZERO:   nextData = '0;
      SRC_STATUS: nextData = 32'(statusIn ^ {1'b0, toggleQ, 6'b0});
      SRC_QUERY:  nextData = 32'(queryByte(ctl.idx, SECT_BYTES, SECT_COUNT, SIZE_LOG2));
      default:    nextData = arrWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      rdValid <= ctl.fire;
      if (ctl.fire) begin
        rdData <= nextData;
        if (ctl.src == SRC_STATUS) toggleQ <= ~toggleQ;
      end
    end
  end

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_read_mux_pkg::*;
#(
  parameter int          SECT_BYTES = 256,
  parameter int          SECT_COUNT = 2,
  parameter int          DEV_BYTES  = 2,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  parameter logic [15:0] DEV_ID     = 16'h227E,
  parameter logic [15:0] EXT_ID_A   = 16'h2210,
  parameter logic [15:0] EXT_ID_B   = 16'hFFFF,
  localparam int         ADDR_W     = $clog2(SECT_BYTES * SECT_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic [2:0]        modeIn,
  input  logic [7:0]        statusIn,
  input  logic              progEn,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  rdCtl_t ctl;

  nor_read_mux_ctrl #(
    .DEV_BYTES (DEV_BYTES),
    .EXT_ID_A  (EXT_ID_A),
    .EXT_ID_B  (EXT_ID_B)
  ) u_ctrl (
    .rdStb   (rdStb),
    .addrLow (rdAddr[7:0]),
    .modeIn  (modeIn),
    .ctl     (ctl)
  );

  nor_read_mux_dp #(
    .ADDR_W     (ADDR_W),
    .SECT_BYTES (SECT_BYTES),
    .SECT_COUNT (SECT_COUNT),
    .BIG_ENDIAN (BIG_ENDIAN),
    .MFR_ID     (MFR_ID),
    .DEV_ID     (DEV_ID),
    .EXT_ID_A   (EXT_ID_A),
    .EXT_ID_B   (EXT_ID_B)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rdAddr   (rdAddr),
    .rdSize   (rdSize),
    .statusIn (statusIn),
    .progEn   (progEn),
    .progAddr (progAddr),
    .progData (progData),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/nor_read_mux_chk.sv
module nor_read_mux_chk #(
  parameter int DEV_BYTES = 2,
  parameter int ADDR_W    = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [1:0]        rdSize,
  input logic [2:0]        modeIn,
  input logic [7:0]        statusIn,
  input logic [31:0]       rdData,
  input logic              rdValid
);

  logic [7:0] chkIdx;
  assign chkIdx = (DEV_BYTES == 4) ? {2'b00, rdAddr[7:2]} :
                  (DEV_BYTES == 2) ? {1'b0, rdAddr[7:1]} : rdAddr[7:0];

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> rdValid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !rdValid);
  p_data_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));
  p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdSize == 2'd0 && (modeIn == 3'd0 || modeIn == 3'd1)) |=> rdData[31:8] == 24'd0);
  p_half_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdSize == 2'd1) |=> rdData[31:16] == 16'd0);
  p_unprotected_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeIn == 3'd2 && chkIdx == 8'h02) |=> rdData == 32'd0);
  p_query_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeIn == 3'd3 && chkIdx >= 8'h52) |=> rdData == 32'd0);
  p_status_shape_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeIn >= 3'd4 && modeIn <= 3'd6) |=>
      (rdData[31:8] == 24'd0 && rdData[7] == $past(statusIn[7]) &&
       rdData[5:0] == $past(statusIn[5:0])));

endmodule

bind nor_read_mux nor_read_mux_chk #(
  .DEV_BYTES (DEV_BYTES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStb    (rdStb),
  .rdAddr   (rdAddr),
  .rdSize   (rdSize),
  .modeIn   (modeIn),
  .statusIn (statusIn),
  .rdData   (rdData),
  .rdValid  (rdValid)
);

// File: tb/nor_read_mux_tb.sv
module nor_read_mux_tb;

  localparam int ADDR_W = 9;
  localparam int ARR    = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdStb = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [1:0]        rdSize = '0;
  logic [2:0]        modeIn = '0;
  logic [7:0]        statusIn = '0;
  logic              progEn = 1'b0;
  logic [ADDR_W-1:0] progAddr = '0;
  logic [7:0]        progData = '0;
  logic [31:0]       rdData;
  logic              rdValid;

  int checks = 0;
  int failures = 0;
  bit togg = 1'b0;

  logic [7:0]  model [ARR];
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  nor_read_mux u_dut (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdAddr(rdAddr), .rdSize(rdSize),
    .modeIn(modeIn), .statusIn(statusIn), .progEn(progEn), .progAddr(progAddr),
    .progData(progData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] arrExp(input int a, input int size);
    logic [31:0] v;
    int n;
    n = (size == 0) ? 1 : ((size == 1) ? 2 : 4);
    v = '0;
    for (int k = 0; k < n; k++) v = v | (32'(model[(a + k) % ARR]) << (8 * k));
    return v;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 unexpected valid actual=%08h expected=none", rdData);
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic rd(input int a, input int size, input int mode, input logic [31:0] exp,
                    input string tag);
    @(negedge clk);
    rdAddr = ADDR_W'(a); rdSize = 2'(size); modeIn = 3'(mode); rdStb = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic statusRd(input int mode, input logic [7:0] st, input string tag);
    statusIn = st;
    rd(0, 1, mode, 32'(st ^ (togg ? 8'h40 : 8'h00)), tag);
    togg = ~togg;
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    @(negedge clk);
    progAddr = ADDR_W'(a); progData = d; progEn = 1'b1;
    model[a] = model[a] & d;
    @(negedge clk);
    progEn = 1'b0;
  endtask

  task automatic qry(input int idx, input logic [7:0] exp, input string tag);
    rd(idx << 1, 0, 3, 32'(exp), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < ARR; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rdValid), 32'd0);
    check("R1 reset data", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R10 erased array
    rd(16, 2, 0, 32'hFFFF_FFFF, "R10 erased word");
    rd(511, 0, 0, 32'h0000_00FF, "R10 erased last byte");

    for (int i = 0; i < ARR; i++) prog(i, 8'((i * 37 + 11) ^ (i >> 3)));
    prog(64, 8'hF3);
    rd(64, 0, 0, 32'(model[64]), "R10 second program ANDs");

    // R3 / R4 array reads
    rd(5, 0, 0, arrExp(5, 0), "R3 R4 byte read");
    rd(6, 1, 0, arrExp(6, 1), "R3 half read");
    rd(8, 2, 0, arrExp(8, 2), "R3 word read");
    rd(510, 2, 0, arrExp(510, 2), "R3 wrap read");
    rd(100, 2, 1, arrExp(100, 2), "R3 erase-setup read");
    rd(33, 1, 7, arrExp(33, 1), "R11 spare mode");

    // R5 / R6 autoselect, R2 index
    rd(0, 1, 2, 32'h0001, "R5 manufacturer");
    rd(1, 1, 2, 32'h0001, "R2 odd address same index");
    rd(2, 1, 2, 32'h227E, "R5 device");
    rd(4, 1, 2, 32'h0000, "R5 protection zero");
    rd(28, 1, 2, 32'h2210, "R6 extended A");
    rd(30, 1, 2, arrExp(30, 1), "R6 blank extended B falls back");
    rd(48, 2, 2, arrExp(48, 2), "R6 other index array");

    // R7 / R8 query table
    qry(8'h10, 8'h51, "R7 Q");
    rd(8'h21, 0, 3, 32'h51, "R2 query odd address");
    qry(8'h11, 8'h52, "R7 R");
    qry(8'h12, 8'h59, "R7 Y");
    qry(8'h13, 8'h02, "R7 command set");
    qry(8'h15, 8'h31, "R7 ext pointer");
    qry(8'h1C, 8'h36, "R7 0x1C");
    qry(8'h21, 8'h09, "R7 typ block erase");
    qry(8'h22, 8'h0C, "R7 typ chip erase");
    qry(8'h25, 8'h0A, "R7 max block erase");
    qry(8'h26, 8'h0D, "R7 max chip erase");
    qry(8'h27, 8'h09, "R7 size log2");
    qry(8'h2A, 8'h00, "R7 no buffer");
    qry(8'h2C, 8'h01, "R7 regions");
    qry(8'h2D, 8'h01, "R7 count low");
    qry(8'h2E, 8'h00, "R7 count high");
    qry(8'h2F, 8'h01, "R7 size low");
    qry(8'h30, 8'h00, "R7 size high");
    qry(8'h31, 8'h50, "R7 P");
    qry(8'h34, 8'h31, "R7 version 1");
    qry(8'h35, 8'h30, "R7 version 0");
    qry(8'h51, 8'h00, "R7 unlisted");
    qry(8'h52, 8'h00, "R8 first beyond");
    qry(8'h7F, 8'h00, "R8 last index");

    // R9 status alternation
    statusRd(4, 8'h80, "R9 program first");
    statusRd(5, 8'h80, "R9 chip erase toggled");
    rd(12, 0, 0, arrExp(12, 0), "R9 array read between");
    statusRd(6, 8'h80, "R9 sector erase back");
    statusRd(4, 8'h25, "R9 new status toggled");

    repeat (4) @(negedge clk);
    check("R1 queue drained", 32'(expQ.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule